// File: doc/BRIEF.md
# Serial-Loaded Bank Controller

This block maps a processor's program window and a video character window onto larger memories by bank number. The processor writes to it one bit at a time. Each accepted write to the upper half of the address space either clears the serial state or shifts data bit 0 into a five-bit buffer, least significant bit first. The fifth bit completes a value. That value is committed to one of four internal registers, chosen by address bits 14:13 of the fifth write.

The four registers are control, character-low, character-high and program. They drive the following outputs, all combinationally from the registers:

- a two-bit nametable mirroring code;
- two 4 KB character bank numbers;
- two 16 KB program bank numbers, one for the window at 0x8000 and one for the window at 0xC000.

A new value appears on the outputs in the cycle after the clock edge that accepts the fifth write.

Top module: `sbank_ctrl`

## Requirements
- R1: A write is taken only when `cpuWr` is high and `cpuAddr[15]` is 1. Writes with `cpuAddr[15]` = 0 change neither the registers nor the outputs.
- R2: Each taken write with data bit 7 clear shifts data bit 0 into the buffer, least significant bit first. On the fifth such write, the five-bit value is committed to the register selected by address bits 14:13 (0 control, 1 character-low, 2 character-high, 3 program), and the buffer and count are cleared. The outputs do not change before that fifth write.
- R3: A taken write with data bit 7 set clears the buffer and count, and sets control bits 3 and 2. Control bits 4, 1 and 0 keep their values.
- R4: A taken write whose address bits 14:13 differ from those of the previous taken write discards any partial buffer first. Its own bit then becomes bit 0 of a new sequence.
- R5: When `cpuWr` with `cpuAddr[15]` = 1 is high on consecutive cycles, only the first of those cycles is taken.
- R6: `mirror` equals control bits 1:0, with this encoding: 0 = single screen, lower page; 1 = single screen, upper page; 2 = vertical; 3 = horizontal.
- R7: With control bit 4 set, `chrBankLo` is the character-low register and `chrBankHi` is the character-high register. With bit 4 clear, the two outputs are the character-low register with bit 0 forced to 0 and to 1 respectively.
- R8: With control bit 3 clear, `prgBankLo` and `prgBankHi` are the program register (truncated to the output width) with bit 0 forced to 0 and to 1 respectively.
- R9: With control bit 3 set, the 16 KB program mode depends on control bit 2:
  - bit 2 = 1: `prgBankLo` is the program register and `prgBankHi` is the last bank (all ones).
  - bit 2 = 0: `prgBankLo` is bank 0 and `prgBankHi` is the program register.
- R10: After reset, control is 0x0C and the other registers are 0. With the default widths this gives the outputs `prgBankLo`=0, `prgBankHi`=15, `chrBankLo`=0, `chrBankHi`=1 and `mirror`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one CPU cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address of the current cycle |
| cpuData | input | 8 | CPU write data |
| cpuWr | input | 1 | Write strobe for the current cycle |
| prgBankLo | output | PRG_W | 16 KB bank number for the window at 0x8000 |
| prgBankHi | output | PRG_W | 16 KB bank number for the window at 0xC000 |
| chrBankLo | output | CHR_W | 4 KB bank number for the character window at 0x0000 |
| chrBankHi | output | CHR_W | 4 KB bank number for the character window at 0x1000 |
| mirror | output | 2 | Mirroring code (see R6) |

## Verification
The assertions take for granted that `cpuAddr` and `cpuData` are steady whenever `cpuWr` is high at a clock edge. They also assume one CPU write occupies exactly one strobe cycle. A strobe held longer than one cycle is therefore read as a burst of back-to-back writes, of which only the first counts. The stimulus changes inputs only on the falling edge and follows every write with an idle cycle. The one exception is the deliberate two-cycle bursts, which use opposite data bits so that a taken second write would corrupt the committed value.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
  localparam int REG_W = 5;
  localparam int CNT_W = $clog2(REG_W + 1);
  localparam int NUM_REGS = 4;
  localparam logic [REG_W-1:0] CTRL_RST = 5'h0C;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef struct packed {
    logic             commit;
    logic             resetCtrl;
    logic [1:0]       sel;
    logic [REG_W-1:0] value;
  } strobe_t;
endpackage

// File: rtl/sbank_ctrl_seq.sv
module sbank_ctrl_seq
  import sbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuData,
  input  logic        cpuWr,
  output strobe_t     strobes
);
  logic             wrQual, prevQual, accept;
  logic [1:0]       region, lastRegion;
  logic             regionChg;
  logic [REG_W-1:0] shiftBuf, effBuf, nextBuf;
  logic [CNT_W-1:0] bitCnt, effCnt;
  logic             lastBit;

  assign wrQual    = cpuWr && cpuAddr[15];
  assign accept    = wrQual && !prevQual;
  assign region    = cpuAddr[14:13];
  assign regionChg = (region != lastRegion);
  assign effCnt    = regionChg ? '0 : bitCnt;
  assign effBuf    = regionChg ? '0 : shiftBuf;
  assign nextBuf   = effBuf | (REG_W'(cpuData[0]) << effCnt);
  assign lastBit   = (effCnt == CNT_W'(REG_W - 1));

  always_comb begin
    strobes.resetCtrl = accept && cpuData[7];
    strobes.commit    = accept && !cpuData[7] && lastBit;
    strobes.sel       = region;
    strobes.value     = nextBuf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevQual   <= 1'b0;
      lastRegion <= '0;
      shiftBuf   <= '0;
      bitCnt     <= '0;
    end else begin
      prevQual <= wrQual;
      if (accept) begin
        lastRegion <= region;
        if (cpuData[7] || lastBit) begin
          shiftBuf <= '0;
          bitCnt   <= '0;
        end else begin
          shiftBuf <= nextBuf;
          bitCnt   <= effCnt + 1'b1;
        end
      end
    end
  end

  // R2: the count never reaches the register width
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt < CNT_W'(REG_W));

  // R3: a bit-7 write leaves the serial state empty
  assert_reset_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrQual && !prevQual && cpuData[7]) |=> (bitCnt == '0 && shiftBuf == '0));

  // R5: the second of two back-to-back writes leaves the serial state alone
  assert_no_b2b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrQual && prevQual) |=> ($stable(bitCnt) && $stable(shiftBuf)));

  // R1: no write strobe, no change
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrQual |=> ($stable(bitCnt) && $stable(shiftBuf)));
endmodule

// File: rtl/sbank_regs_dp.sv
module sbank_regs_dp
  import sbank_pkg::*;
#(
  parameter int PRG_W = 4,
  parameter int CHR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strobes,
  output logic [PRG_W-1:0] prgBankLo,
  output logic [PRG_W-1:0] prgBankHi,
  output logic [CHR_W-1:0] chrBankLo,
  output logic [CHR_W-1:0] chrBankHi,
  output logic [1:0]       mirror
);
  localparam logic [PRG_W-1:0] PRG_LAST = '1;

  logic [REG_W-1:0] regFile [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [REG_W-1:0] RST_VAL = (i == 0) ? CTRL_RST : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        regFile[i] <= RST_VAL;
      else if (strobes.commit && strobes.sel == 2'(i))
        regFile[i] <= strobes.value;
      else if (i == 0 && strobes.resetCtrl)
        regFile[i] <= regFile[i] | 5'h0C;
    end
  end

  logic [REG_W-1:0] ctrlReg;
  logic [PRG_W-1:0] prgSel;
  logic [CHR_W-1:0] chrLoSel, chrHiSel;

  assign ctrlReg  = regFile[0];
  assign prgSel   = PRG_W'(regFile[3]);
  assign chrLoSel = CHR_W'(regFile[1]);
  assign chrHiSel = CHR_W'(regFile[2]);

  always_comb begin
    mirror = ctrlReg[1:0];
    if (ctrlReg[4]) begin
      chrBankLo = chrLoSel;
      chrBankHi = chrHiSel;
    end else begin
      chrBankLo = {chrLoSel[CHR_W-1:1], 1'b0};
      chrBankHi = {chrLoSel[CHR_W-1:1], 1'b1};
    end
    if (!ctrlReg[3]) begin
      prgBankLo = {prgSel[PRG_W-1:1], 1'b0};
      prgBankHi = {prgSel[PRG_W-1:1], 1'b1};
    end else if (ctrlReg[2]) begin
      prgBankLo = prgSel;
      prgBankHi = PRG_LAST;
    end else begin
      prgBankLo = '0;
      prgBankHi = prgSel;
    end
  end

  // R3: bit-7 write forces bits 3:2 and keeps the rest
  assert_ctrl_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.resetCtrl && !strobes.commit) |=>
      (regFile[0][3:2] == 2'b11 && regFile[0][4] == $past(regFile[0][4])
       && regFile[0][1:0] == $past(regFile[0][1:0])));

  // R2: registers move only on a commit or a bit-7 write
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.commit && !strobes.resetCtrl) |=>
      ($stable(regFile[0]) && $stable(regFile[1]) && $stable(regFile[2]) && $stable(regFile[3])));

  // R9: in 16 KB modes one window is always pinned
  assert_fixed_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlReg[3] |-> (prgBankHi == PRG_LAST || prgBankLo == '0));

  // R8: 32 KB mode gives an even/odd pair
  assert_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlReg[3] |-> (prgBankHi == (prgBankLo | PRG_W'(1))));
endmodule

// File: rtl/sbank_ctrl.sv
module sbank_ctrl #(
  parameter int PRG_W = 4,
  parameter int CHR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cpuAddr,
  input  logic [7:0]       cpuData,
  input  logic             cpuWr,
  output logic [PRG_W-1:0] prgBankLo,
  output logic [PRG_W-1:0] prgBankHi,
  output logic [CHR_W-1:0] chrBankLo,
  output logic [CHR_W-1:0] chrBankHi,
  output logic [1:0]       mirror
);
  sbank_pkg::strobe_t strobes;

  sbank_ctrl_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpuAddr (cpuAddr),
    .cpuData (cpuData),
    .cpuWr   (cpuWr),
    .strobes (strobes)
  );

  sbank_regs_dp #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .prgBankLo (prgBankLo),
    .prgBankHi (prgBankHi),
    .chrBankLo (chrBankLo),
    .chrBankHi (chrBankHi),
    .mirror    (mirror)
  );
endmodule

// File: tb/sbank_ctrl_bench.sv
module sbank_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWr = 1'b0;
  logic [3:0]  prgBankLo, prgBankHi;
  logic [4:0]  chrBankLo, chrBankHi;
  logic [1:0]  mirror;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sbank_ctrl u_sbank_ctrl (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWr(cpuWr),
    .prgBankLo(prgBankLo), .prgBankHi(prgBankHi),
    .chrBankLo(chrBankLo), .chrBankHi(chrBankHi), .mirror(mirror)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic [4:0] val;
    logic [3:0] lo;
    logic [3:0] hi;
    logic [4:0] c0;
    logic [4:0] c1;
    logic [1:0] mir;
  } vec_t;

  // cumulative: each row loads one register, then all outputs are compared
  localparam vec_t VECS [8] = '{
    '{2'd3, 5'h05, 4'd5,  4'd15, 5'd0, 5'd1,  2'd0},  // R9 fix-last
    '{2'd0, 5'h03, 4'd4,  4'd5,  5'd0, 5'd1,  2'd3},  // R8 R6
    '{2'd0, 5'h1A, 4'd0,  4'd5,  5'd0, 5'd0,  2'd2},  // R9 fix-first, R7
    '{2'd1, 5'h07, 4'd0,  4'd5,  5'd7, 5'd0,  2'd2},  // R7
    '{2'd2, 5'h1E, 4'd0,  4'd5,  5'd7, 5'd30, 2'd2},  // R7
    '{2'd0, 5'h05, 4'd4,  4'd5,  5'd6, 5'd7,  2'd1},  // R7 8K, R8
    '{2'd3, 5'h1B, 4'd10, 4'd11, 5'd6, 5'd7,  2'd1},  // R8 truncation
    '{2'd0, 5'h1C, 4'd11, 4'd15, 5'd7, 5'd30, 2'd0}   // R9 R6
  };

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic burstWrite(input logic [15:0] a, input logic b);
    @(negedge clk);
    cpuAddr = a; cpuData = {7'd0, b}; cpuWr = 1'b1;
    @(negedge clk);
    cpuData = {7'd0, ~b};
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic loadReg(input logic [15:0] a, input logic [4:0] v);
    for (int i = 0; i < 5; i++) cpuWrite(a, {7'd0, v[i]});
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] lo, input logic [3:0] hi,
                       input logic [4:0] c0, input logic [4:0] c1, input logic [1:0] mir);
    compared++;
    if (prgBankLo !== lo || prgBankHi !== hi || chrBankLo !== c0 ||
        chrBankHi !== c1 || mirror !== mir) begin
      mismatched++;
      $display("FAIL %s: got prg %0d/%0d chr %0d/%0d mir %0d, expected prg %0d/%0d chr %0d/%0d mir %0d",
               req, prgBankLo, prgBankHi, chrBankLo, chrBankHi, mirror, lo, hi, c0, c1, mir);
    end
  endtask

  function automatic logic [15:0] regAddr(input logic [1:0] sel);
    return {1'b1, sel, 13'h0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset state", 4'd0, 4'd15, 5'd0, 5'd1, 2'd0);

    for (int k = 0; k < 8; k++) begin
      loadReg(regAddr(VECS[k].sel), VECS[k].val);
      check($sformatf("R2 vector %0d", k), VECS[k].lo, VECS[k].hi, VECS[k].c0, VECS[k].c1, VECS[k].mir);
    end

    loadReg(16'h8000, 5'h13);
    check("R8 32K with control 0x13", 4'd10, 4'd11, 5'd7, 5'd30, 2'd3);

    cpuWrite(16'hE000, 8'h01);
    cpuWrite(16'hE000, 8'h01);
    cpuWrite(16'hE000, 8'h80);
    @(negedge clk);
    check("R3 bit-7 write forces bits 3:2", 4'd11, 4'd15, 5'd7, 5'd30, 2'd3);
    loadReg(16'hE000, 5'h02);
    check("R3 partial buffer discarded", 4'd2, 4'd15, 5'd7, 5'd30, 2'd3);

    for (int i = 0; i < 3; i++) cpuWrite(16'hA000, 8'h01);
    loadReg(16'hC000, 5'h05);
    check("R4 region change discards partial", 4'd2, 4'd15, 5'd7, 5'd5, 2'd3);

    burstWrite(16'hA000, 1'b1);
    burstWrite(16'hA000, 1'b1);
    burstWrite(16'hA000, 1'b0);
    burstWrite(16'hA000, 1'b0);
    @(negedge clk);
    check("R2 no change before fifth write", 4'd2, 4'd15, 5'd7, 5'd5, 2'd3);
    burstWrite(16'hA000, 1'b0);
    @(negedge clk);
    check("R5 back-to-back second write ignored", 4'd2, 4'd15, 5'd3, 5'd5, 2'd3);

    loadReg(16'h8000, 5'h10);
    check("R8 32K with control 0x10", 4'd2, 4'd3, 5'd3, 5'd5, 2'd0);
    cpuWrite(16'h6000, 8'h80);
    @(negedge clk);
    check("R1 low address bit-7 write ignored", 4'd2, 4'd3, 5'd3, 5'd5, 2'd0);
    loadReg(16'h6000, 5'h1F);
    check("R1 low address serial writes ignored", 4'd2, 4'd3, 5'd3, 5'd5, 2'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule